// File: doc/BRIEF.md
# AUX Request to I2C Bridge

This block sits behind a DisplayPort-style auxiliary channel front end. It takes one request at a time and returns one reply code. A request has a 4-bit command, a 20-bit address, a byte count of 0 to 16 and a byte buffer. The buffer is reached through an indexed port: the bridge reads outgoing bytes from it and writes incoming bytes back into it.

Native commands turn into single-byte accesses on a local register port that spans a 1 MiB space. I2C commands drive a byte-level I2C master through start, byte-transfer and stop operations. Between requests the bridge remembers whether the I2C bus is still held and which address and command last held it. A run of middle-of-transaction requests can therefore stream through one open I2C transaction. The bridge issues a new start only when the target or the direction changes.

Top module: `aux_i2c_bridge`

## Requirements
- R1: Command codes: 4'h8 native write, 4'h9 native read, 4'h0 I2C write, 4'h1 I2C read, 4'h4 I2C write that keeps the bus open (MOT), 4'h5 I2C read with MOT. Reply codes: 2'b00 ACK, 2'b01 AUX NACK, 2'b10 I2C NACK. Any other command gets AUX NACK and causes no bus activity.
- R2: A native request of N bytes makes N single-byte register accesses at address, address+1, and so on. A write sends buffer byte i to address+i. A read stores the byte from address+i into buffer index i.
- R3: A native request with a count of zero replies AUX NACK and makes no access. A register error ends the request at that byte and replies AUX NACK. If every byte succeeds, the reply is ACK.
- R4: A plain I2C command first sends a stop if the bus is open, then a start to the low 7 address bits with the command's direction. If the start is not acknowledged, the reply is I2C NACK and no stop follows.
- R5: After an acknowledged start, a plain I2C command transfers the bytes in order. It aborts at the first byte that is not acknowledged. It always ends with a stop and leaves the bus closed. The reply is ACK only if all bytes completed, and I2C NACK otherwise.
- R6: A MOT command sends a start if the bus is closed. If the bus is open with the same 20-bit address and command as the last MOT request, it goes straight to the bytes with no start. If either the address or the command differs, it sends a stop and then a start.
- R7: A MOT command that completes all its bytes replies ACK and leaves the bus open with no stop. A byte failure sends a stop and replies I2C NACK. A start that is not acknowledged replies I2C NACK and leaves the bus closed.
- R8: `req_ready` is high only while the bridge is idle. It drops in the cycle after a request is accepted. Each request produces exactly one single-cycle `rsp_valid` pulse.
- R9: On I2C reads, byte i received in a request is stored into buffer index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, request accepted when both high |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Register or I2C address |
| req_len | input | 5 | Byte count, 0 to 16 |
| buf_idx | output | 4 | Buffer byte index |
| buf_wdata | input | 8 | Buffer byte at buf_idx (outgoing data) |
| buf_we | output | 1 | Store buf_rdata at buf_idx |
| buf_rdata | output | 8 | Incoming byte to store |
| reg_req | output | 1 | Register access, held until reg_ack |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 20 | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_ack | input | 1 | Register access complete |
| reg_err | input | 1 | Register access failed (valid with reg_ack) |
| reg_rdata | input | 8 | Register read byte (valid with reg_ack) |
| i2c_cmd_valid | output | 1 | I2C operation, held until i2c_done |
| i2c_op | output | 2 | 0 start, 1 byte transfer, 2 stop |
| i2c_addr | output | 7 | Target address for start |
| i2c_rnw | output | 1 | Direction, 1 for read |
| i2c_wdata | output | 8 | Byte to send |
| i2c_done | input | 1 | Operation complete |
| i2c_ack | input | 1 | Start or byte acknowledged (valid with i2c_done) |
| i2c_rdata | input | 8 | Received byte (valid with i2c_done) |
| rsp_valid | output | 1 | Single-cycle reply strobe |
| rsp_code | output | 2 | Reply code |

## Verification
The bench chains MOT requests to test the restart decision three ways: same context, a changed command, and an address that differs only above bit 6. A bridge that compared only the 7-bit I2C address would skip the stop and start in the last case. A bridge that always restarted would add a start to the continue case. A plain command issued while MOT holds the bus must first send a stop. A plain command with a failing byte must still end with a stop. A MOT failure must close the bus, so the next MOT request must start again. The bench also checks an unacknowledged start, which must not be followed by a stop, and a native request that runs into the error region, which must stop after exactly three accesses. It also checks a zero-length native request, which must make no access at all.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;
  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;

  typedef enum logic [1:0] {
    RSP_ACK      = 2'b00,
    RSP_AUX_NACK = 2'b01,
    RSP_I2C_NACK = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_XFER  = 2'd1,
    OP_STOP  = 2'd2
  } i2c_op_e;

  typedef enum logic [1:0] {
    CLS_NAT,
    CLS_I2C,
    CLS_MOT,
    CLS_BAD
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_NAT,
    ST_PRESTOP,
    ST_START,
    ST_XFER,
    ST_POSTSTOP,
    ST_REPLY
  } st_e;
endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
  import aux_bridge_pkg::*;
(
  input  logic [3:0] cmd,
  output cls_e       cls,
  output logic       rnw
);
  always_comb begin
    rnw = 1'b0;
    unique case (cmd)
      CMD_NAT_WR: cls = CLS_NAT;
      CMD_NAT_RD: begin cls = CLS_NAT; rnw = 1'b1; end
      CMD_I2C_WR: cls = CLS_I2C;
      CMD_I2C_RD: begin cls = CLS_I2C; rnw = 1'b1; end
      CMD_MOT_WR: cls = CLS_MOT;
      CMD_MOT_RD: begin cls = CLS_MOT; rnw = 1'b1; end
      default:    cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/aux_mot_track.sv
module aux_mot_track #(
  parameter int ADDR_W = 20,
  parameter int CMD_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_set,
  input  logic              open_clr,
  input  logic              rec,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic              bus_open,
  output logic              same_ctx
);
  logic [ADDR_W-1:0] last_addr;
  logic [CMD_W-1:0]  last_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_open  <= 1'b0;
      last_addr <= '0;
      last_cmd  <= '0;
    end else begin
      if (open_clr)      bus_open <= 1'b0;
      else if (open_set) bus_open <= 1'b1;
      if (rec) begin
        last_addr <= addr_i;
        last_cmd  <= cmd_i;
      end
    end
  end

  assign same_ctx = (addr_i == last_addr) && (cmd_i == last_cmd);
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
  import aux_bridge_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int MAX_LEN = 16,
  parameter int I2C_AW  = 7,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic [IDX_W-1:0]  buf_idx,
  input  logic [7:0]        buf_wdata,
  output logic              buf_we,
  output logic [7:0]        buf_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_ack,
  input  logic              reg_err,
  input  logic [7:0]        reg_rdata,
  output logic              i2c_cmd_valid,
  output logic [1:0]        i2c_op,
  output logic [I2C_AW-1:0] i2c_addr,
  output logic              i2c_rnw,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_done,
  input  logic              i2c_ack,
  input  logic [7:0]        i2c_rdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code
);
  st_e               st;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q, cnt;
  rsp_e              code_q;
  cls_e              cls;
  logic              rnw, bus_open, same_ctx, last_byte;
  logic              open_set, open_clr, rec;

  aux_cmd_decode u_dec (.cmd(cmd_q), .cls(cls), .rnw(rnw));

  aux_mot_track #(.ADDR_W(ADDR_W), .CMD_W(4)) u_trk (
    .clk(clk), .rst(rst), .open_set(open_set), .open_clr(open_clr), .rec(rec),
    .addr_i(addr_q), .cmd_i(cmd_q), .bus_open(bus_open), .same_ctx(same_ctx)
  );

  assign last_byte = (cnt + LEN_W'(1)) == len_q;
  assign open_clr  = i2c_done && (st == ST_PRESTOP || st == ST_POSTSTOP);
  assign open_set  = i2c_done && i2c_ack && (st == ST_START);
  assign rec       = open_set && (cls == CLS_MOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      cnt    <= '0;
      code_q <= RSP_ACK;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          cmd_q  <= req_cmd;
          addr_q <= req_addr;
          len_q  <= req_len;
          cnt    <= '0;
          st     <= ST_DECIDE;
        end
        ST_DECIDE: unique case (cls)
          CLS_NAT: if (len_q == '0) begin
            code_q <= RSP_AUX_NACK;
            st     <= ST_REPLY;
          end else st <= ST_NAT;
          CLS_I2C: st <= bus_open ? ST_PRESTOP : ST_START;
          CLS_MOT: if (!bus_open) st <= ST_START;
            else if (!same_ctx) st <= ST_PRESTOP;
            else if (len_q == '0) begin
              code_q <= RSP_ACK;
              st     <= ST_REPLY;
            end else st <= ST_XFER;
          default: begin
            code_q <= RSP_AUX_NACK;
            st     <= ST_REPLY;
          end
        endcase
        ST_NAT: if (reg_ack) begin
          if (reg_err) begin
            code_q <= RSP_AUX_NACK;
            st     <= ST_REPLY;
          end else if (last_byte) begin
            code_q <= RSP_ACK;
            st     <= ST_REPLY;
          end else cnt <= cnt + LEN_W'(1);
        end
        ST_PRESTOP: if (i2c_done) st <= ST_START;
        ST_START: if (i2c_done) begin
          if (!i2c_ack) begin
            code_q <= RSP_I2C_NACK;
            st     <= ST_REPLY;
          end else if (len_q == '0) begin
            code_q <= RSP_ACK;
            st     <= (cls == CLS_MOT) ? ST_REPLY : ST_POSTSTOP;
          end else st <= ST_XFER;
        end
        ST_XFER: if (i2c_done) begin
          if (!i2c_ack) begin
            code_q <= RSP_I2C_NACK;
            st     <= ST_POSTSTOP;
          end else if (last_byte) begin
            code_q <= RSP_ACK;
            st     <= (cls == CLS_MOT) ? ST_REPLY : ST_POSTSTOP;
          end else cnt <= cnt + LEN_W'(1);
        end
        ST_POSTSTOP: if (i2c_done) st <= ST_REPLY;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign buf_idx       = cnt[IDX_W-1:0];
  assign reg_req       = (st == ST_NAT);
  assign reg_we        = !rnw;
  assign reg_addr      = addr_q + ADDR_W'(cnt);
  assign reg_wdata     = buf_wdata;
  assign buf_we        = rnw && ((st == ST_NAT && reg_ack && !reg_err) ||
                                 (st == ST_XFER && i2c_done && i2c_ack));
  assign buf_rdata     = (st == ST_NAT) ? reg_rdata : i2c_rdata;
  assign i2c_cmd_valid = (st == ST_PRESTOP) || (st == ST_START) ||
                         (st == ST_XFER) || (st == ST_POSTSTOP);
  assign i2c_op        = (st == ST_START) ? OP_START :
                         (st == ST_XFER)  ? OP_XFER  : OP_STOP;
  assign i2c_addr      = addr_q[I2C_AW-1:0];
  assign i2c_rnw       = rnw;
  assign i2c_wdata     = buf_wdata;
  assign rsp_valid     = (st == ST_REPLY);
  assign rsp_code      = code_q;

  // R2: consecutive native bytes advance the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_req && reg_ack && !reg_err) |=> (!reg_req || reg_addr == $past(reg_addr) + 1'b1));
  // R5: a plain I2C request always leaves the bus released
  p_plain_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cls == CLS_I2C) |-> !bus_open);
  // R7: an acknowledged MOT request keeps the bus held
  p_mot_held_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cls == CLS_MOT && rsp_code == RSP_ACK) |-> bus_open);
  // R8: busy right after acceptance
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R8: reply strobe lasts one cycle
  p_reply_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R1: never drive both downstream ports at once
  p_one_port_r1: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && i2c_cmd_valid));
endmodule

// File: tb/tb_aux_i2c_bridge.sv
module tb_aux_i2c_bridge;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [4:0]  req_len = '0;
  logic [3:0]  buf_idx;
  logic [7:0]  buf_wdata, buf_rdata;
  logic        buf_we;
  logic        reg_req, reg_we, reg_ack, reg_err;
  logic [19:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        i2c_cmd_valid, i2c_rnw, i2c_done, i2c_ack;
  logic [1:0]  i2c_op;
  logic [6:0]  i2c_addr;
  logic [7:0]  i2c_wdata, i2c_rdata;
  logic        rsp_valid;
  logic [1:0]  rsp_code;

  aux_i2c_bridge dut (.*);

  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [7:0] mem  [256];
  int oplog [1024];
  int op_wr = 0, xfer_total = 0, reg_total = 0, xbase = 0, fail_at = -1;
  int nchk = 0, nfail = 0, nrep = 0;

  assign buf_wdata = wbuf[buf_idx];
  always @(posedge clk) if (buf_we) rbuf[buf_idx] <= buf_rdata;

  // Register port responder: addresses with top nibble F fail
  always @(posedge clk) begin
    if (rst) reg_ack <= 1'b0;
    else if (reg_req && !reg_ack) begin
      reg_ack   <= 1'b1;
      reg_err   <= (reg_addr[19:16] == 4'hF);
      reg_rdata <= mem[reg_addr[7:0]];
      if (reg_we && reg_addr[19:16] != 4'hF) mem[reg_addr[7:0]] <= reg_wdata;
      reg_total <= reg_total + 1;
    end else reg_ack <= 1'b0;
  end

  // I2C responder: target 7'h50 acknowledges; byte number fail_at fails
  always @(posedge clk) begin
    if (rst) i2c_done <= 1'b0;
    else if (i2c_cmd_valid && !i2c_done) begin
      i2c_done <= 1'b1;
      oplog[op_wr] <= int'(i2c_op) + 1;
      op_wr <= op_wr + 1;
      if (i2c_op == 2'd0) i2c_ack <= (i2c_addr == 7'h50);
      else if (i2c_op == 2'd1) begin
        i2c_ack    <= ((xfer_total - xbase) != fail_at);
        i2c_rdata  <= 8'hC0 + 8'(xfer_total - xbase);
        xfer_total <= xfer_total + 1;
      end else i2c_ack <= 1'b1;
    end else i2c_done <= 1'b0;
  end

  typedef struct {
    logic [1:0]  code;
    logic [63:0] ops;
    int          nreg;
    int          obase;
    int          rbase;
    string       req;
  } exp_t;
  exp_t scq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Monitor: pop expectation on each reply
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (scq.size() == 0) chk(1'b0, "R8", "unexpected reply", 64'(rsp_code), 64'h0);
      else begin
        exp_t e;
        logic [63:0] seen;
        e = scq.pop_front();
        seen = '0;
        for (int i = e.obase; i < op_wr; i++) seen = (seen << 2) | 64'(oplog[i]);
        chk(rsp_code == e.code, e.req, "reply code", 64'(rsp_code), 64'(e.code));
        chk(seen == e.ops, e.req, "I2C op trace", seen, e.ops);
        chk((reg_total - e.rbase) == e.nreg, e.req, "register accesses",
            64'(reg_total - e.rbase), 64'(e.nreg));
      end
      nrep++;
    end
  end

  // Reference model of the restart policy
  bit m_open = 0;
  logic [19:0] m_addr = '0;
  logic [3:0]  m_cmd = '0;

  task automatic model(input logic [3:0] cmd, input logic [19:0] a, input int len,
                       input int fail, output logic [1:0] code,
                       output logic [63:0] ops, output int nreg);
    ops = '0; nreg = 0; code = 2'b00;
    if (cmd == 4'h8 || cmd == 4'h9) begin
      if (len == 0) code = 2'b01;
      for (int i = 0; i < len; i++) begin
        logic [19:0] x;
        x = a + 20'(i);
        nreg++;
        if (x[19:16] == 4'hF) begin code = 2'b01; break; end
      end
    end else if (cmd == 4'h0 || cmd == 4'h1) begin
      if (m_open) begin ops = (ops << 2) | 3; m_open = 0; end
      ops = (ops << 2) | 1;
      if (a[6:0] != 7'h50) begin code = 2'b10; return; end
      for (int i = 0; i < len; i++) begin
        ops = (ops << 2) | 2;
        if (i == fail) begin code = 2'b10; break; end
      end
      ops = (ops << 2) | 3;
    end else if (cmd == 4'h4 || cmd == 4'h5) begin
      if (!m_open || a != m_addr || cmd != m_cmd) begin
        if (m_open) begin ops = (ops << 2) | 3; m_open = 0; end
        ops = (ops << 2) | 1;
        if (a[6:0] != 7'h50) begin code = 2'b10; return; end
        m_open = 1;
      end
      m_addr = a; m_cmd = cmd;
      for (int i = 0; i < len; i++) begin
        ops = (ops << 2) | 2;
        if (i == fail) begin ops = (ops << 2) | 3; m_open = 0; code = 2'b10; return; end
      end
    end else code = 2'b01;
  endtask

  // Driver: predict, enqueue, issue, wait for the reply
  task automatic do_req(input logic [3:0] cmd, input logic [19:0] a, input int len,
                        input int fail, input string req);
    exp_t e;
    int target;
    model(cmd, a, len, fail, e.code, e.ops, e.nreg);
    e.obase = op_wr; e.rbase = reg_total; e.req = req;
    scq.push_back(e);
    xbase = xfer_total; fail_at = fail;
    target = nrep + 1;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_len = 5'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait (nrep == target);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready after reset", 64'(req_ready), 64'h1);
    chk(rsp_valid == 1'b0 && reg_req == 1'b0 && i2c_cmd_valid == 1'b0, "R8",
        "quiet after reset", 64'({rsp_valid, reg_req, i2c_cmd_valid}), 64'h0);

    do_req(4'h3, 20'h00050, 2, -1, "R1");                 // undefined command
    do_req(4'hA, 20'h00050, 0, -1, "R1");
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h10 + 8'(i * 7);
    do_req(4'h8, 20'h00120, 4, -1, "R2");                 // native write
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h00;
    do_req(4'h9, 20'h00120, 4, -1, "R2");                 // native read back
    for (int i = 0; i < 4; i++)
      chk(rbuf[i] == 8'h10 + 8'(i * 7), "R2", "native read byte",
          64'(rbuf[i]), 64'(8'h10 + 8'(i * 7)));
    do_req(4'h8, 20'h00120, 0, -1, "R3");                 // zero length
    do_req(4'h8, 20'hEFFFE, 4, -1, "R3");                 // third byte fails
    do_req(4'h0, 20'h00050, 2, -1, "R4");                 // plain write
    do_req(4'h1, 20'h00033, 2, -1, "R4");                 // start refused
    do_req(4'h0, 20'h00050, 3, 1, "R5");                  // byte 1 fails
    do_req(4'h0, 20'h00050, 0, -1, "R5");                 // zero-length plain
    do_req(4'h4, 20'h00050, 2, -1, "R6");                 // MOT open
    do_req(4'h4, 20'h00050, 1, -1, "R6");                 // continue
    do_req(4'h4, 20'h00050, 0, -1, "R6");                 // continue, no bytes
    do_req(4'h5, 20'h00050, 2, -1, "R9");                 // direction change
    chk(rbuf[0] == 8'hC0 && rbuf[1] == 8'hC1, "R9", "I2C read bytes",
        64'({rbuf[0], rbuf[1]}), 64'h0000_C0C1);
    do_req(4'h1, 20'h00050, 2, -1, "R4");                 // plain while held
    do_req(4'h4, 20'h00050, 1, -1, "R6");
    do_req(4'h4, 20'h00150, 1, -1, "R6");                 // upper address bits differ
    do_req(4'h4, 20'h00150, 2, 0, "R7");                  // MOT byte failure
    do_req(4'h4, 20'h00033, 1, -1, "R7");                 // MOT start refused
    do_req(4'h4, 20'h00050, 1, -1, "R7");                 // fresh start after close
    chk(scq.size() == 0, "R8", "replies outstanding", 64'(scq.size()), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 64'(nrep), 64'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule